// File: doc/BRIEF.md
# Host Bus Ready/Wait Handshake

This block is the host-facing end of a peripheral that sits on an asynchronous CPU memory bus. The bus carries a 23-bit address and a 16-bit data word. It has two active-low chip selects, one for register space and one for memory space. It also has an active-low read strobe and two active-low byte write strobes, one for each byte lane. The block brings the chip selects and strobes into the system clock domain through a two-stage synchronizer. For each access it issues one request on a simple internal port and waits for that port's acknowledge.

The block tells the host how the access is going on two handshake pins. The pins use opposite conventions. The ready pin goes low when the access has completed. The wait pin goes low during a write until the access has been taken. Each pin has three levels. It floats when no chip select is active. It drives high while a chip select is active but no strobe is active. It drives its active level during a strobe as described above. Each three-state pin is modelled as a value plus an output enable. The data bus output enable follows the read strobe and chip selects directly, so that the pads turn around without synchronizer delay.

Top module: `host_bus_handshake`

## Requirements
- R1: `rdy_oe` and `wait_oe` are 0 whenever neither synchronized chip select is active, and 1 whenever at least one is active.
- R2: While a synchronized chip select is active and no synchronized strobe is active, `rdy_o` and `wait_o` are both 1.
- R3: During a synchronized strobe, `rdy_o` is 0 exactly while the handshake is in its completed state (after acknowledge, before strobe release), and 1 otherwise. `rdy_o` and `wait_o` are never both 0.
- R4: During a synchronized write strobe, `wait_o` is 0 until the acknowledge has been taken and 1 from then on. During a read, `wait_o` stays 1.
- R5: `cpu_rdata_oe` is 1 exactly when `rd_n` is 0 and at least one of `cs_reg_n` and `cs_mem_n` is 0, taken straight from the pins with no clock delay.
- R6: A change on a chip select or strobe pin reaches the handshake logic after two rising clock edges, through a two-flop synchronizer.
- R7: When the handshake is idle and a synchronized strobe is seen under a chip select, `req_valid` is high for exactly one cycle starting at the next rising edge. In that cycle the request carries `cpu_addr`. It also carries `req_space` (0 = register space, 1 = memory space; register space wins if both selects are active) and `req_write` (1 for a write, 0 when the read strobe is active).
- R8: `req_be[1]` marks the upper byte (`wr_hi_n`) and `req_be[0]` the lower byte (`wr_lo_n`). A write drives only the lanes whose strobe is active and leaves the other lanes of `req_wdata` at zero. A read gives `req_be` = 2'b11 and `req_wdata` = 0.
- R9: `req_ack` is taken only while a request is outstanding. It then captures `req_rdata`, and that word appears on `cpu_rdata`. An acknowledge at any other time changes neither the state nor `cpu_rdata`.
- R10: After the acknowledge, the block holds the completed state until the strobe or chip select is released. A strobe that is held issues no second request.
- R11: After reset the handshake pins float, no request is pending and the handshake is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 23 | Host address |
| cpu_wdata | input | 16 | Host write data |
| cpu_rdata | output | 16 | Host read data |
| cpu_rdata_oe | output | 1 | Data bus output enable |
| cs_reg_n | input | 1 | Register-space chip select, active low |
| cs_mem_n | input | 1 | Memory-space chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_hi_n | input | 1 | Upper-byte write strobe, active low |
| wr_lo_n | input | 1 | Lower-byte write strobe, active low |
| rdy_o | output | 1 | Ready pin level |
| rdy_oe | output | 1 | Ready pin enable |
| wait_o | output | 1 | Wait pin level |
| wait_oe | output | 1 | Wait pin enable |
| req_valid | output | 1 | One-cycle internal request |
| req_space | output | 1 | 0 register space, 1 memory space |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 23 | Request address |
| req_be | output | 2 | Byte enables (bit 1 upper) |
| req_wdata | output | 16 | Request write data |
| req_ack | input | 1 | Internal acknowledge |
| req_rdata | input | 16 | Read data with acknowledge |

## Verification
The assertions assume a well-behaved host. It keeps address and write data stable from the strobe edge until the handshake completes, and it holds each strobe until ready goes low. They also assume the internal port raises its acknowledge only in answer to a request. The stimulus respects this. It sets the chip select first, then address, data and strobes together, and waits for ready before releasing anything. Stray acknowledges are sent only to test that they are ignored, once while idle and once in the completed state.

// File: rtl/hbh_pkg.sv
package hbh_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BUSY = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;

  typedef enum logic {
    SPACE_REG = 1'b0,
    SPACE_MEM = 1'b1
  } hs_space_e;
endpackage

// File: rtl/hbh_sync.sv
module hbh_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{{WIDTH{RST_VAL}}}};
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbh_fsm.sv
module hbh_fsm
  import hbh_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic [1:0]    lane_act,
  input  logic          reg_sel,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          req_ack,
  input  logic [DW-1:0] req_rdata,
  output logic          done,
  output logic          req_valid,
  output logic          req_space,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_be,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned LW = DW / 2;

  hs_state_e     state_q, state_d;
  logic          strobe, launch, capture, is_write;
  logic [1:0]    be_d;
  logic [DW-1:0] wdata_d;

  assign strobe   = rd_act | wr_act;
  assign launch   = (state_q == HS_IDLE) & strobe;
  assign capture  = (state_q == HS_BUSY) & req_ack;
  assign is_write = wr_act & ~rd_act;
  assign be_d     = is_write ? lane_act : 2'b11;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign wdata_d[g*LW +: LW] = (is_write & lane_act[g]) ? cpu_wdata[g*LW +: LW] : '0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (strobe)  state_d = HS_BUSY;
      HS_BUSY: if (req_ack) state_d = HS_DONE;
      HS_DONE: if (!strobe) state_d = HS_IDLE;
      default:              state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      req_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_valid <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_space <= SPACE_REG;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_be    <= '0;
      req_wdata <= '0;
    end else if (launch) begin
      req_space <= reg_sel ? SPACE_REG : SPACE_MEM;
      req_write <= is_write;
      req_addr  <= cpu_addr;
      req_be    <= be_d;
      req_wdata <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= req_rdata;
  end

  assign done = (state_q == HS_DONE);

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  p_be_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != 2'b00));
  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_ack));
  p_rdata_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(rdata));
endmodule

// File: rtl/hbh_pin_drive.sv
module hbh_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic rd_act,
  input  logic wr_act,
  input  logic done,
  output logic rdy_o,
  output logic rdy_oe,
  output logic wait_o,
  output logic wait_oe
);
  logic strobe;
  assign strobe  = rd_act | wr_act;
  assign rdy_oe  = cs_act;
  assign wait_oe = cs_act;
  assign rdy_o   = ~(strobe & done);
  assign wait_o  = ~(wr_act & ~done);

  p_never_both_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe |-> (rdy_o || wait_o));
endmodule

// File: rtl/host_bus_handshake.sv
module host_bus_handshake
  import hbh_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_oe,
  input  logic          cs_reg_n,
  input  logic          cs_mem_n,
  input  logic          rd_n,
  input  logic          wr_hi_n,
  input  logic          wr_lo_n,
  output logic          rdy_o,
  output logic          rdy_oe,
  output logic          wait_o,
  output logic          wait_oe,
  output logic          req_valid,
  output logic          req_space,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_be,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ack,
  input  logic [DW-1:0] req_rdata
);
  localparam int unsigned NPIN = 5;

  logic [0:0]      rst_q;
  logic            rst_int_n;
  logic [NPIN-1:0] pin_s;
  logic            cs_act, rd_act, wr_act, reg_sel, done;
  logic [1:0]      lane_act;

  hbh_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );
  assign rst_int_n = rst_q[0];

  hbh_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({cs_reg_n, cs_mem_n, rd_n, wr_hi_n, wr_lo_n}),
    .q(pin_s)
  );

  assign reg_sel  = ~pin_s[4];
  assign cs_act   = ~pin_s[4] | ~pin_s[3];
  assign rd_act   = cs_act & ~pin_s[2];
  assign lane_act = ~pin_s[1:0];
  assign wr_act   = cs_act & (|lane_act);

  hbh_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .rd_act(rd_act), .wr_act(wr_act),
    .lane_act(lane_act), .reg_sel(reg_sel), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
    .done(done), .req_valid(req_valid), .req_space(req_space),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rdata(cpu_rdata)
  );

  hbh_pin_drive u_pins (
    .clk(clk), .rst_n(rst_int_n), .cs_act(cs_act), .rd_act(rd_act),
    .wr_act(wr_act), .done(done), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
    .wait_o(wait_o), .wait_oe(wait_oe)
  );

  assign cpu_rdata_oe = ~rd_n & (~cs_reg_n | ~cs_mem_n);

  p_req_needs_select_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |-> $past(rdy_oe));
endmodule

// File: tb/tb_host_bus_handshake.sv
module tb_host_bus_handshake;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_rdata_oe;
  logic        cs_reg_n = 1'b1, cs_mem_n = 1'b1, rd_n = 1'b1, wr_hi_n = 1'b1, wr_lo_n = 1'b1;
  logic        rdy_o, rdy_oe, wait_o, wait_oe;
  logic        req_valid, req_space, req_write;
  logic [22:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        req_ack = 1'b0;
  logic [15:0] req_rdata = '0;

  int checks = 0;
  int errors = 0;
  int ack_dly = 0;
  logic inj = 1'b0;
  logic cmp_en = 1'b0;
  logic [15:0] rd_word = 16'h1357;

  always #(PERIOD/2) clk = ~clk;

  host_bus_handshake dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe), .cs_reg_n(cs_reg_n),
    .cs_mem_n(cs_mem_n), .rd_n(rd_n), .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe), .wait_o(wait_o), .wait_oe(wait_oe),
    .req_valid(req_valid), .req_space(req_space), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history, handshake phase, captured request.
  logic [4:0]  m_s1, m_s2;
  int          m_st;
  logic        m_req, m_space, m_write;
  logic [22:0] m_addr;
  logic [1:0]  m_be;
  logic [15:0] m_wdata, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_st = 0; m_req = 0; m_rdata = '0;
      m_space = 0; m_write = 0; m_addr = '0; m_be = '0; m_wdata = '0;
    end else begin
      bit cs, rd, wr;
      cs = !m_s2[4] || !m_s2[3];
      rd = cs && !m_s2[2];
      wr = cs && (!m_s2[1] || !m_s2[0]);
      m_req = 0;
      case (m_st)
        0: if (rd || wr) begin
             m_st = 1; m_req = 1; m_addr = cpu_addr;
             m_space = m_s2[4];
             m_write = wr && !rd;
             m_be = m_write ? ~m_s2[1:0] : 2'b11;
             m_wdata = m_write ? {m_s2[1] ? 8'h00 : cpu_wdata[15:8],
                                  m_s2[0] ? 8'h00 : cpu_wdata[7:0]} : 16'h0;
           end
        1: if (req_ack) begin m_rdata = req_rdata; m_st = 2; end
        default: if (!(rd || wr)) m_st = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = {cs_reg_n, cs_mem_n, rd_n, wr_hi_n, wr_lo_n};
    end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n && cmp_en) begin
      bit e_cs, e_rd, e_wr, e_doe;
      e_cs = !m_s2[4] || !m_s2[3];
      e_rd = e_cs && !m_s2[2];
      e_wr = e_cs && (!m_s2[1] || !m_s2[0]);
      e_doe = !rd_n && (!cs_reg_n || !cs_mem_n);
      chk("R1/R6 rdy_oe", rdy_oe, e_cs);
      chk("R1 wait_oe", wait_oe, e_cs);
      if (e_cs) begin
        chk("R2/R3 rdy_o", rdy_o, !((e_rd || e_wr) && m_st == 2));
        chk("R2/R4 wait_o", wait_o, !(e_wr && m_st != 2));
      end
      chk("R5 data_oe", cpu_rdata_oe, e_doe);
      if (e_doe) chk("R9 cpu_rdata", cpu_rdata, m_rdata);
      chk("R7/R10 req_valid", req_valid, m_req);
      if (m_req) begin
        chk("R7 req_addr", req_addr, m_addr);
        chk("R7 req_space", req_space, m_space);
        chk("R7 req_write", req_write, m_write);
        chk("R8 req_be", req_be, m_be);
        chk("R8 req_wdata", req_wdata, m_wdata);
      end
    end
  end

  // Internal port responder, with optional stray acknowledge injection.
  initial begin
    forever begin
      @(negedge clk);
      if (inj) begin
        req_ack = 1'b1; req_rdata = 16'hDEAD;
        @(negedge clk);
        req_ack = 1'b0; inj = 1'b0;
      end else if (req_valid) begin
        repeat (ack_dly) @(negedge clk);
        req_ack = 1'b1; req_rdata = rd_word;
        rd_word = rd_word + 16'h1111;
        @(negedge clk);
        req_ack = 1'b0;
      end
    end
  end

  task automatic access(input int sel, input bit rd, input logic [1:0] lanes,
                        input logic [22:0] a, input logic [15:0] d,
                        input int dly, input bit stray);
    @(negedge clk);
    cs_reg_n = !(sel == 0 || sel == 2);
    cs_mem_n = !(sel == 1 || sel == 2);
    repeat (3) @(negedge clk);
    ack_dly = dly;
    cpu_addr = a; cpu_wdata = d;
    rd_n = !rd;
    wr_hi_n = !(lanes[1] && !rd);
    wr_lo_n = !(lanes[0] && !rd);
    while (!(rdy_oe && !rdy_o)) @(negedge clk);
    if (stray) inj = 1'b1;
    repeat (4) @(negedge clk);
    rd_n = 1'b1; wr_hi_n = 1'b1; wr_lo_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_reg_n = 1'b1; cs_mem_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 rdy_oe", rdy_oe, 1'b0);
    chk("R11 wait_oe", wait_oe, 1'b0);
    chk("R11 req_valid", req_valid, 1'b0);
    cmp_en = 1'b1;
    access(0, 0, 2'b11, 23'h12_3456, 16'hA5C3, 0, 0); // R8 both lanes
    access(1, 0, 2'b10, 23'h7F_FFFF, 16'hBEEF, 2, 0); // R8 upper lane only
    access(1, 0, 2'b01, 23'h00_0001, 16'hCAFE, 5, 0); // R8 lower lane only
    access(0, 1, 2'b00, 23'h40_0000, 16'h0000, 1, 0); // R9 register read
    access(1, 1, 2'b00, 23'h2A_AAAA, 16'h0000, 3, 1); // R9 stray ack in done
    access(2, 1, 2'b00, 23'h55_5555, 16'h0000, 0, 0); // R7 register priority
    inj = 1'b1;                                       // R9 stray ack when idle
    repeat (6) @(negedge clk);
    access(1, 0, 2'b11, 23'h11_1111, 16'h1234, 7, 0); // R10 long hold
    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule